// File: doc/BRIEF.md
# NOR Flash Erase and Program Sequencer

This block runs one complete erase or program operation on a parallel NOR flash device. It handles either of two command-set families. The first family uses a status register with a ready bit and error flags. The second family uses a two-write unlock handshake and signals that it is busy with a bit that toggles. The host gives a single start pulse. With it come the operation kind, the family, the sector base word address, the target word address and the data word. The block then issues the family's bus write cycles and polls the device until the operation ends or a cycle budget runs out. It finishes with a one-cycle done pulse and a three-bit result code.

The flash is reached through a simple synchronous memory port. A request is held with a fixed address, direction and write data until the port acknowledges it. Read data is taken in the cycle of the acknowledge. All addresses are word addresses. Command bytes are zero-extended to the data width.

Top module: `nor_cmd_seq`

## Requirements
- R1: A status-register-family sector erase writes 0x50, then 0x20, then 0xD0, all to the sector base address.
- R2: A toggle-family sector erase writes 0xAA at base+0x555, 0x55 at base+0x2AA and 0x80 at base+0x555. It then writes 0xAA at base+0x555 and 0x55 at base+0x2AA again, and finally 0x30 at the sector base.
- R3: A status-register-family program writes 0x50, then 0x40, then the data word, all to the target address.
- R4: A toggle-family program writes 0xAA at base+0x555, 0x55 at base+0x2AA and 0xA0 at base+0x555, then the data word at the target address.
- R5: In the status-register family the device is busy while read bit 7 is 0. Polling reads the target address for a program and the sector base for an erase. When the operation finishes, with or without an error, the block writes 0xFF to the sector base before done.
- R6: In the toggle family the operation is complete when bit 6 is equal in two consecutive status reads. A successful finish in this family writes no reset command.
- R7: When a status-register-family device reports ready, the status byte is decoded in this priority order:
  - bit 1 set gives code 4 (locked);
  - bits 5 and 4 both set give code 5 (sequence error);
  - bit 5 set gives code 2 (erase failure);
  - bit 4 set gives code 3 (locking error);
  - bit 3 set gives code 6 (low programming voltage);
  - otherwise the code is 0 (success).
- R8: The cycle budget is taken from erase_limit for an erase and from write_limit for a program. The cycle count restarts at every accepted start. If the count has reached the budget when a poll is due, the block writes the family's reset command to the sector base and ends with code 1. The reset command is 0xFF for the status-register family and 0xF0 for the toggle family.
- R9: Before any program write, the target word is read. If the data needs a 1 in any bit that already reads 0, the block ends with code 7 and issues no write.
- R10: An erase started with sect_prot high issues no bus cycle. It ends with done and code 4 in the cycle after the start. sect_prot has no effect on a program.
- R11: A bus request keeps its address, direction and write data unchanged until it is acknowledged. No request is made while the block is idle. A start pulse that arrives while the block is busy is ignored.
- R12: After reset, busy, done, mem_req and err_code are 0. Done is a one-cycle pulse, and busy is low in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse, accepted only while idle |
| op_erase | input | 1 | 1 selects sector erase, 0 selects word program |
| fam_toggle | input | 1 | 1 selects the toggle-bit family, 0 the status-register family |
| sect_base | input | AW | Sector base word address |
| tgt_addr | input | AW | Target word address for program |
| wr_word | input | DW | Data word to program |
| sect_prot | input | 1 | Sector is marked protected |
| erase_limit | input | TW | Cycle budget for an erase |
| write_limit | input | TW | Cycle budget for a program |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| err_code | output | 3 | Result code, held until the next start |
| mem_req | output | 1 | Bus request |
| mem_we | output | 1 | Bus request is a write |
| mem_addr | output | AW | Bus word address |
| mem_wdata | output | DW | Bus write data |
| mem_ack | input | 1 | Bus acknowledge |
| mem_rdata | input | DW | Bus read data, valid with mem_ack |

## Verification
The bench goes after these corner cases:
- **Error-bit overlaps.** Bit 1 combined with bits 5 and 4, and bits 5 and 4 together. A decoder with the wrong priority would report a sequence or erase failure where a locked block is expected.
- **Unchanged poll values.** A device that is ready on the first read, and a toggle device whose first two reads already match. A poller that counts one read too many or too few would hang, or would finish early with a wrong write trace.
- **Not-erased boundary.** Data that needs exactly the bits that still read 1 must be accepted. Data needing one bit that reads 0 must be refused with no writes.
- **Cycle budget.** A timeout is followed by an operation that must succeed, and an erase runs with a tiny write_limit. A count that is not cleared at start, or a budget taken from the wrong input, would report false timeouts.
- **Reset command after a timeout.** A missing reset write, or one with the wrong family's command, shows up in the recorded write trace.
- **Start while busy.** A design that accepted this second start would corrupt the recorded write trace.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_PRECHK,
    S_CMD,
    S_PCHK,
    S_PRD,
    S_RSTW,
    S_FIN
  } seq_state_t;

  localparam logic [2:0] RC_OK    = 3'd0;
  localparam logic [2:0] RC_TMO   = 3'd1;
  localparam logic [2:0] RC_ERASE = 3'd2;
  localparam logic [2:0] RC_LOCK  = 3'd3;
  localparam logic [2:0] RC_PROT  = 3'd4;
  localparam logic [2:0] RC_SEQ   = 3'd5;
  localparam logic [2:0] RC_VPP   = 3'd6;
  localparam logic [2:0] RC_NERA  = 3'd7;

  localparam logic [7:0] CMD_CLRST  = 8'h50;
  localparam logic [7:0] CMD_BERASE = 8'h20;
  localparam logic [7:0] CMD_CONF   = 8'hD0;
  localparam logic [7:0] CMD_WORD   = 8'h40;
  localparam logic [7:0] CMD_RDARR  = 8'hFF;
  localparam logic [7:0] TGL_UNLK1  = 8'hAA;
  localparam logic [7:0] TGL_UNLK2  = 8'h55;
  localparam logic [7:0] TGL_ESETUP = 8'h80;
  localparam logic [7:0] TGL_SERASE = 8'h30;
  localparam logic [7:0] TGL_PROG   = 8'hA0;
  localparam logic [7:0] TGL_RESET  = 8'hF0;

  localparam int STEP_W = 3;

endpackage

// File: rtl/nor_cmd_rom.sv
module nor_cmd_rom
  import nor_seq_pkg::*;
#(
  parameter int AW = 20,
  parameter int DW = 16
) (
  input  logic              fam_toggle,
  input  logic              op_erase,
  input  logic [STEP_W-1:0] step,
  input  logic [AW-1:0]     base,
  input  logic [AW-1:0]     tgt,
  input  logic [DW-1:0]     wdat,
  output logic [AW-1:0]     wr_addr,
  output logic [DW-1:0]     wr_data,
  output logic              last
);

  localparam logic [AW-1:0] OFS_A = AW'(12'h555);
  localparam logic [AW-1:0] OFS_B = AW'(12'h2AA);
  localparam int            PADW  = DW - 8;

  logic [AW-1:0] a_first;
  logic [AW-1:0] a_second;

  assign a_first  = base + OFS_A;
  assign a_second = base + OFS_B;

  function automatic logic [DW-1:0] widen(input logic [7:0] c);
    return {{PADW{1'b0}}, c};
  endfunction

  always_comb begin
    wr_addr = base;
    wr_data = '0;
    last    = 1'b0;
    unique case ({fam_toggle, op_erase})
      2'b01: begin
        wr_addr = base;
        unique case (step)
          3'd0:    wr_data = widen(CMD_CLRST);
          3'd1:    wr_data = widen(CMD_BERASE);
          default: begin wr_data = widen(CMD_CONF); last = 1'b1; end
        endcase
      end
      2'b00: begin
        wr_addr = tgt;
        unique case (step)
          3'd0:    wr_data = widen(CMD_CLRST);
          3'd1:    wr_data = widen(CMD_WORD);
          default: begin wr_data = wdat; last = 1'b1; end
        endcase
      end
      2'b11: begin
        unique case (step)
          3'd0, 3'd3: begin wr_addr = a_first;  wr_data = widen(TGL_UNLK1); end
          3'd1, 3'd4: begin wr_addr = a_second; wr_data = widen(TGL_UNLK2); end
          3'd2:       begin wr_addr = a_first;  wr_data = widen(TGL_ESETUP); end
          default:    begin wr_addr = base; wr_data = widen(TGL_SERASE); last = 1'b1; end
        endcase
      end
      default: begin
        unique case (step)
          3'd0:    begin wr_addr = a_first;  wr_data = widen(TGL_UNLK1); end
          3'd1:    begin wr_addr = a_second; wr_data = widen(TGL_UNLK2); end
          3'd2:    begin wr_addr = a_first;  wr_data = widen(TGL_PROG); end
          default: begin wr_addr = tgt; wr_data = wdat; last = 1'b1; end
        endcase
      end
    endcase
  end

endmodule

// File: rtl/nor_stat_dec.sv
module nor_stat_dec
  import nor_seq_pkg::*;
(
  input  logic       b5,
  input  logic       b4,
  input  logic       b3,
  input  logic       b1,
  output logic [2:0] code
);

  always_comb begin
    if (b1)             code = RC_PROT;
    else if (b5 && b4)  code = RC_SEQ;
    else if (b5)        code = RC_ERASE;
    else if (b4)        code = RC_LOCK;
    else if (b3)        code = RC_VPP;
    else                code = RC_OK;
  end

endmodule

// File: rtl/nor_tmo_cnt.sv
module nor_tmo_cnt #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          en,
  input  logic [TW-1:0] limit,
  output logic          hit
);

  logic [TW-1:0] cnt_q;
  logic [TW-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)                    cnt_d = '0;
    else if (en && !(&cnt_q))   cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign hit = (cnt_q >= limit);

endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
  import nor_seq_pkg::*;
#(
  parameter int AW = 20,
  parameter int DW = 16,
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          op_erase,
  input  logic          fam_toggle,
  input  logic [AW-1:0] sect_base,
  input  logic [AW-1:0] tgt_addr,
  input  logic [DW-1:0] wr_word,
  input  logic          sect_prot,
  input  logic [TW-1:0] erase_limit,
  input  logic [TW-1:0] write_limit,
  output logic          busy,
  output logic          done,
  output logic [2:0]    err_code,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata
);

  localparam int PADW = DW - 8;

  seq_state_t        state_q, state_d;
  logic [STEP_W-1:0] step_q, step_d;
  logic [2:0]        err_q, err_d;
  logic              prev_q, prev_d;
  logic              have_q, have_d;

  logic              fam_q, erase_q;
  logic [AW-1:0]     base_q, tgt_q;
  logic [DW-1:0]     data_q;
  logic [TW-1:0]     lim_q;

  logic              accept;
  logic [AW-1:0]     rom_addr;
  logic [DW-1:0]     rom_data;
  logic              rom_last;
  logic [2:0]        dec_code;
  logic              tmo_hit;

  assign accept = (state_q == S_IDLE) && start;

  nor_cmd_rom #(.AW(AW), .DW(DW)) u_rom (
    .fam_toggle (fam_q),
    .op_erase   (erase_q),
    .step       (step_q),
    .base       (base_q),
    .tgt        (tgt_q),
    .wdat       (data_q),
    .wr_addr    (rom_addr),
    .wr_data    (rom_data),
    .last       (rom_last)
  );

  nor_stat_dec u_dec (
    .b5   (mem_rdata[5]),
    .b4   (mem_rdata[4]),
    .b3   (mem_rdata[3]),
    .b1   (mem_rdata[1]),
    .code (dec_code)
  );

  nor_tmo_cnt #(.TW(TW)) u_tmo (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (accept),
    .en    (busy),
    .limit (lim_q),
    .hit   (tmo_hit)
  );

  // next-state logic
  always_comb begin
    state_d = state_q;
    step_d  = step_q;
    err_d   = err_q;
    prev_d  = prev_q;
    have_d  = have_q;
    unique case (state_q)
      S_IDLE: begin
        if (start) begin
          err_d  = RC_OK;
          step_d = '0;
          have_d = 1'b0;
          if (op_erase && sect_prot) begin
            err_d   = RC_PROT;
            state_d = S_FIN;
          end else if (!op_erase) begin
            state_d = S_PRECHK;
          end else begin
            state_d = S_CMD;
          end
        end
      end
      S_PRECHK: begin
        if (mem_ack) begin
          if ((data_q & ~mem_rdata) != '0) begin
            err_d   = RC_NERA;
            state_d = S_FIN;
          end else begin
            state_d = S_CMD;
          end
        end
      end
      S_CMD: begin
        if (mem_ack) begin
          if (rom_last) state_d = S_PCHK;
          else          step_d  = step_q + 1'b1;
        end
      end
      S_PCHK: begin
        if (tmo_hit) begin
          err_d   = RC_TMO;
          state_d = S_RSTW;
        end else begin
          state_d = S_PRD;
        end
      end
      S_PRD: begin
        if (mem_ack) begin
          if (!fam_q) begin
            if (mem_rdata[7]) begin
              err_d   = dec_code;
              state_d = S_RSTW;
            end else begin
              state_d = S_PCHK;
            end
          end else if (have_q && (mem_rdata[6] == prev_q)) begin
            state_d = S_FIN;
          end else begin
            prev_d  = mem_rdata[6];
            have_d  = 1'b1;
            state_d = S_PCHK;
          end
        end
      end
      S_RSTW: begin
        if (mem_ack) state_d = S_FIN;
      end
      default: state_d = S_IDLE;
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      step_q  <= '0;
      err_q   <= RC_OK;
      prev_q  <= 1'b0;
      have_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      step_q  <= step_d;
      err_q   <= err_d;
      prev_q  <= prev_d;
      have_q  <= have_d;
    end
  end

  // operation parameters, loaded on accepted start
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fam_q   <= 1'b0;
      erase_q <= 1'b0;
      base_q  <= '0;
      tgt_q   <= '0;
      data_q  <= '0;
      lim_q   <= '0;
    end else if (accept) begin
      fam_q   <= fam_toggle;
      erase_q <= op_erase;
      base_q  <= sect_base;
      tgt_q   <= tgt_addr;
      data_q  <= wr_word;
      lim_q   <= op_erase ? erase_limit : write_limit;
    end
  end

  // bus and status outputs
  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    unique case (state_q)
      S_PRECHK: begin
        mem_req  = 1'b1;
        mem_addr = tgt_q;
      end
      S_CMD: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = rom_addr;
        mem_wdata = rom_data;
      end
      S_PRD: begin
        mem_req  = 1'b1;
        mem_addr = erase_q ? base_q : tgt_q;
      end
      S_RSTW: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = base_q;
        mem_wdata = {{PADW{1'b0}}, (fam_q ? TGL_RESET : CMD_RDARR)};
      end
      default: ;
    endcase
  end

  assign busy     = (state_q != S_IDLE);
  assign done     = (state_q == S_FIN);
  assign err_code = err_q;

endmodule

// File: rtl/nor_cmd_seq_chk.sv
module nor_cmd_seq_chk #(
  parameter int AW = 20,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          op_erase,
  input logic          sect_prot,
  input logic          busy,
  input logic          done,
  input logic [2:0]    err_code,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_wdata,
  input logic          mem_ack
);

  // R10: protected erase refused next cycle with code 4
  p_prot_refuse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && op_erase && sect_prot) |=> (done && err_code == 3'd4));

  // R11: request held until acknowledged
  p_bus_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                               && $stable(mem_wdata)));

  // R11: no bus activity while idle
  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req);

  // R12: done is a single pulse and busy drops after it
  p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

endmodule

bind nor_cmd_seq nor_cmd_seq_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .op_erase  (op_erase),
  .sect_prot (sect_prot),
  .busy      (busy),
  .done      (done),
  .err_code  (err_code),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .mem_ack   (mem_ack)
);

// File: tb/nor_cmd_seq_bench.sv
module nor_cmd_seq_bench;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 20;
  localparam int DW = 16;
  localparam int TW = 16;
  localparam int BIG = 1 << 20;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          op_erase = 1'b0;
  logic          fam_toggle = 1'b0;
  logic [AW-1:0] sect_base = '0;
  logic [AW-1:0] tgt_addr = '0;
  logic [DW-1:0] wr_word = '0;
  logic          sect_prot = 1'b0;
  logic [TW-1:0] erase_limit = '0;
  logic [TW-1:0] write_limit = '0;
  logic          busy, done;
  logic [2:0]    err_code;
  logic          mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic          mem_ack = 1'b0;
  logic [DW-1:0] mem_rdata = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nor_cmd_seq #(.AW(AW), .DW(DW), .TW(TW)) u_nor_cmd_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .op_erase(op_erase),
    .fam_toggle(fam_toggle), .sect_base(sect_base), .tgt_addr(tgt_addr),
    .wr_word(wr_word), .sect_prot(sect_prot), .erase_limit(erase_limit),
    .write_limit(write_limit), .busy(busy), .done(done), .err_code(err_code),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  // flash model parameters
  logic          m_prog = 1'b0;
  logic          m_fam = 1'b0;
  logic [DW-1:0] m_arr = '0;
  int            m_nbusy = 0;
  logic [7:0]    m_fin = 8'h80;

  int            rcnt = 0;
  int            logn = 0;
  int            wcnt = 0;
  int            dly = 0;
  logic [AW-1:0] log_a [32];
  logic [DW-1:0] log_d [32];

  int            n_chk = 0;
  int            n_fail = 0;

  logic [AW-1:0] exp_a [16];
  logic [DW-1:0] exp_d [16];
  int            exp_n;

  function automatic logic [DW-1:0] rd_val(input int rc);
    int k;
    logic b;
    if (m_prog && rc == 0) return m_arr;
    k = m_prog ? rc - 1 : rc;
    if (!m_fam) begin
      if (k < m_nbusy) return '0;
      return {8'h00, m_fin};
    end
    b = (k < m_nbusy) ? ((k % 2) != 0) : (((m_nbusy + 1) % 2) != 0);
    return {9'b0, b, 6'b0};
  endfunction

  always @(posedge clk) begin
    if (start && !busy) begin
      rcnt <= 0;
      logn <= 0;
    end else if (mem_ack) begin
      mem_ack <= 1'b0;
    end else if (mem_req) begin
      if (wcnt >= dly) begin
        mem_ack <= 1'b1;
        wcnt    <= 0;
        dly     <= int'($urandom % 3);
        if (mem_we) begin
          if (logn < 32) begin
            log_a[logn] <= mem_addr;
            log_d[logn] <= mem_wdata;
          end
          logn <= logn + 1;
        end else begin
          mem_rdata <= rd_val(rcnt);
          rcnt      <= rcnt + 1;
        end
      end else begin
        wcnt <= wcnt + 1;
      end
    end
  end

  // status decode from R7
  function automatic logic [2:0] dec_stat(input logic [7:0] s);
    if (s[1])               return 3'd4;
    if (s[5] && s[4])       return 3'd5;
    if (s[5])               return 3'd2;
    if (s[4])               return 3'd3;
    if (s[3])               return 3'd6;
    return 3'd0;
  endfunction

  function automatic logic [2:0] exp_code(input logic fam, input logic ers,
      input logic prot, input logic [DW-1:0] arr, input logic [DW-1:0] dat,
      input logic tmo, input logic [7:0] fin);
    if (ers && prot)                 return 3'd4;
    if (!ers && ((dat & ~arr) != 0)) return 3'd7;
    if (tmo)                         return 3'd1;
    if (fam)                         return 3'd0;
    return dec_stat(fin);
  endfunction

  task automatic push(input logic [AW-1:0] a, input logic [DW-1:0] d);
    exp_a[exp_n] = a;
    exp_d[exp_n] = d;
    exp_n++;
  endtask

  task automatic build_exp(input logic fam, input logic ers, input logic [AW-1:0] b,
      input logic [AW-1:0] t, input logic [DW-1:0] dat, input logic [2:0] code,
      input logic tmo);
    exp_n = 0;
    if (code == 3'd7 || (code == 3'd4 && ers && fam)) return;
    if (code == 3'd4 && ers && tmo == 1'b0 && fam == 1'b0 && exp_n == 0 && prot_flag) return;
    if (!fam && ers) begin
      push(b, 16'h50); push(b, 16'h20); push(b, 16'hD0);
    end else if (!fam) begin
      push(t, 16'h50); push(t, 16'h40); push(t, dat);
    end else if (ers) begin
      push(b + 20'h555, 16'hAA); push(b + 20'h2AA, 16'h55); push(b + 20'h555, 16'h80);
      push(b + 20'h555, 16'hAA); push(b + 20'h2AA, 16'h55); push(b, 16'h30);
    end else begin
      push(b + 20'h555, 16'hAA); push(b + 20'h2AA, 16'h55); push(b + 20'h555, 16'hA0);
      push(t, dat);
    end
    if (!fam)     push(b, 16'hFF);
    else if (tmo) push(b, 16'hF0);
  endtask

  logic prot_flag = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
      input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wait_done(input string req);
    int w;
    w = 0;
    while (!done && w < 20000) begin
      @(negedge clk);
      w++;
    end
    if (!done) check(1'b0, req, "watchdog no done", 0, 1);
  endtask

  task automatic cmp_log(input string req);
    bit ok;
    int bad;
    ok = (logn == exp_n);
    bad = -1;
    for (int i = 0; i < exp_n && i < 32; i++) begin
      if (ok && (log_a[i] !== exp_a[i] || log_d[i] !== exp_d[i])) begin
        ok = 1'b0;
        bad = i;
      end
    end
    if (bad >= 0)
      check(ok, req, $sformatf("write %0d addr/data", bad),
            int'({log_a[bad], log_d[bad]}), int'({exp_a[bad], exp_d[bad]}));
    else
      check(ok, req, "write count", logn, exp_n);
  endtask

  task automatic run_op(input logic fam, input logic ers, input logic [AW-1:0] b,
      input logic [AW-1:0] t, input logic [DW-1:0] dat, input logic prot,
      input logic [DW-1:0] arr, input int nb, input logic [7:0] fin,
      input logic [TW-1:0] elim, input logic [TW-1:0] wlim, input logic tmo,
      input string req);
    logic [2:0] ec;
    ec = exp_code(fam, ers, prot, arr, dat, tmo, fin);
    prot_flag = prot;
    build_exp(fam, ers, b, t, dat, ec, tmo);
    if (ec == 3'd4 && ers && prot) exp_n = 0;
    @(negedge clk);
    m_prog = !ers; m_fam = fam; m_arr = arr; m_nbusy = nb; m_fin = fin;
    fam_toggle = fam; op_erase = ers; sect_base = b; tgt_addr = t; wr_word = dat;
    sect_prot = prot; erase_limit = elim; write_limit = wlim;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(req);
    check(err_code == ec, req, "err_code", int'(err_code), int'(ec));
    cmp_log(req);
    @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R12: reset state
    check(busy == 0 && done == 0 && mem_req == 0 && err_code == 0, "R12",
          "reset outputs", int'({busy, done, mem_req, err_code}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    run_op(0, 1, 20'h12000, 20'h12000, 16'h0, 0, 16'hFFFF, 3, 8'h80, 5000, 5000, 0, "R1");
    run_op(1, 1, 20'h34000, 20'h34000, 16'h0, 0, 16'hFFFF, 4, 8'h00, 5000, 5000, 0, "R2");
    run_op(0, 0, 20'h21000, 20'h21abc, 16'h1234, 0, 16'hFFFF, 2, 8'h80, 5000, 5000, 0, "R3");
    run_op(1, 0, 20'h56000, 20'h56123, 16'hBEEF, 0, 16'hFFFF, 3, 8'h00, 5000, 5000, 0, "R4");
    run_op(0, 1, 20'h01000, 20'h01000, 16'h0, 0, 16'hFFFF, 0, 8'h80, 5000, 5000, 0, "R5");
    run_op(1, 0, 20'h02000, 20'h02010, 16'h00FF, 0, 16'hFFFF, 0, 8'h00, 5000, 5000, 0, "R6");
    run_op(0, 1, 20'h03000, 20'h03000, 16'h0, 0, 16'hFFFF, 1, 8'hB0, 5000, 5000, 0, "R7");
    run_op(0, 1, 20'h03000, 20'h03000, 16'h0, 0, 16'hFFFF, 1, 8'hA0, 5000, 5000, 0, "R7");
    run_op(0, 0, 20'h03000, 20'h03004, 16'h0001, 0, 16'hFFFF, 1, 8'h90, 5000, 5000, 0, "R7");
    run_op(0, 1, 20'h03000, 20'h03000, 16'h0, 0, 16'hFFFF, 2, 8'hB2, 5000, 5000, 0, "R7");
    run_op(0, 0, 20'h03000, 20'h03008, 16'h0002, 0, 16'hFFFF, 0, 8'h88, 5000, 5000, 0, "R7");
    run_op(0, 1, 20'h04000, 20'h04000, 16'h0, 0, 16'hFFFF, BIG, 8'h80, 40, 5000, 1, "R8");
    run_op(0, 1, 20'h04000, 20'h04000, 16'h0, 0, 16'hFFFF, 4, 8'h80, 60, 5000, 0, "R8");
    run_op(1, 0, 20'h05000, 20'h05020, 16'h0F00, 0, 16'hFFFF, BIG, 8'h00, 5000, 50, 1, "R8");
    run_op(1, 0, 20'h05000, 20'h05020, 16'h0F00, 0, 16'hFFFF, 2, 8'h00, 5000, 70, 0, "R8");
    run_op(0, 1, 20'h06000, 20'h06000, 16'h0, 0, 16'hFFFF, 3, 8'h80, 5000, 2, 0, "R8");
    run_op(0, 0, 20'h07000, 20'h07001, 16'h0F0F, 0, 16'hFF00, 0, 8'h80, 5000, 5000, 0, "R9");
    run_op(1, 0, 20'h07000, 20'h07001, 16'h0F0F, 0, 16'h0F0F, 1, 8'h00, 5000, 5000, 0, "R9");
    run_op(0, 1, 20'h08000, 20'h08000, 16'h0, 1, 16'hFFFF, 2, 8'h80, 5000, 5000, 0, "R10");
    run_op(1, 1, 20'h08000, 20'h08000, 16'h0, 1, 16'hFFFF, 2, 8'h00, 5000, 5000, 0, "R10");
    run_op(0, 0, 20'h08000, 20'h08002, 16'h0101, 1, 16'hFFFF, 1, 8'h80, 5000, 5000, 0, "R10");

    // R11: start while busy is ignored
    begin
      prot_flag = 1'b0;
      build_exp(0, 1, 20'h09000, 20'h09000, 16'h0, 3'd0, 0);
      @(negedge clk);
      m_prog = 0; m_fam = 0; m_arr = 16'hFFFF; m_nbusy = 20; m_fin = 8'h80;
      fam_toggle = 0; op_erase = 1; sect_base = 20'h09000; tgt_addr = 20'h09000;
      wr_word = 0; sect_prot = 0; erase_limit = 5000; write_limit = 5000;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (6) @(negedge clk);
      fam_toggle = 1; op_erase = 0; sect_base = 20'h0A000; tgt_addr = 20'h0A005;
      wr_word = 16'h5555; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      wait_done("R11");
      check(err_code == 3'd0, "R11", "err_code", int'(err_code), 0);
      cmp_log("R11");
      @(negedge clk);
    end

    // random mix
    for (int it = 0; it < 40; it++) begin
      logic          f, e, p;
      logic [AW-1:0] b, t;
      logic [DW-1:0] d, a;
      logic [7:0]    fs;
      f  = $urandom % 2;
      e  = $urandom % 2;
      p  = (($urandom % 8) == 0);
      b  = {8'($urandom), 12'h000};
      t  = b | 20'($urandom % 4096);
      d  = 16'($urandom);
      a  = ($urandom % 2) ? 16'hFFFF : 16'($urandom);
      fs = {1'b1, 7'($urandom)};
      run_op(f, e, b, t, d, p, a, int'($urandom % 6), fs, 5000, 5000, 0, "R7");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule